// File: doc/BRIEF.md
# Keyed Watchdog with Sticky Register Locks

This block is an 8-bit watchdog down counter for a system controller. It stays idle until software first writes its reload register or its service register. From then on it decrements once per selected tick, and only a reset stops it. The tick is either the periodic timer's output pulse or the timer's input clock enable, chosen by a configuration bit. Both tick sources come in as single-cycle enables in the `clk` domain.

Software keeps the watchdog alive in one of two ways. In plain mode it rewrites the reload value. In keyed mode it writes the fixed key 0x5C to the service register. A service that comes too late, too often, or with the wrong key is flagged on `wd_err` as a one-cycle pulse, and a reset generator outside this block acts on it.

The configuration register holds set-only bits. Four of them are locks: one for the configuration register itself, one for the reload register, and two that are passed out to the neighbouring prescaler and timer. A low-power input closes every register except the service register.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, every configuration bit is 0, the counter is idle, and it reads 0 at address 3. Ticks have no effect on an idle counter, and `wd_err` stays low.
- R2: The first accepted write to address 1 (reload) or address 2 (service) starts the counter. A write to address 1 loads the written value. A write to address 2 loads the stored reload value. Once started, the counter never stops before reset.
- R3: Configuration bit 4 selects the tick. When it is 1 the tick is `tick_tmr_out`; when it is 0 the tick is `tick_clk_in`. The unselected input has no effect.
- R4: A running counter decrements by one on each tick. A tick that finds it at 0 raises the late error and reloads it from the stored reload value. Address 3 reads the live counter.
- R5: With bit 5 clear (plain mode), an accepted write to address 1 stores the value. If the counter is running, the same write is a service that also loads the value into the counter. Address 1 reads the stored value.
- R6: With bit 5 set (keyed mode), writing 0x5C to address 2 is a service that reloads the counter from the stored value. A write to address 1 while running only updates the stored value.
- R7: In keyed mode, writing any value other than 0x5C to address 2 while running raises an error and leaves the counter unchanged.
- R8: A service that arrives with no tick since the previous service or start raises an error and does not reload the counter.
- R9: Each error event produces `wd_err` high for exactly the clock cycle after the event. Back-to-back events give back-to-back pulses.
- R10: Address 0 is set-only. A write ORs data bits 5:0 into the register, writing 0 clears nothing, and bits 7:6 always read 0.
- R11: Configuration bit 0 locks address 0, and bit 3 locks address 1. A locked register ignores writes and reads 0x00. Bits 1 and 2 drive `lock_prescaler` and `lock_timer`.
- R12: While `low_power` is 1, writes to addresses 0 and 1 are ignored and every read returns 0x00. Writes to address 2 still act.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_clk_in | input | 1 | One-cycle enable marking the timer's input clock |
| tick_tmr_out | input | 1 | One-cycle pulse from the timer output |
| low_power | input | 1 | Low-power mode; only the service register is open |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | Register address: 0 config, 1 reload, 2 service, 3 live count |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| lock_prescaler | output | 1 | Lock for the neighbouring prescaler register |
| lock_timer | output | 1 | Lock for the neighbouring timer reload register |
| wd_err | output | 1 | One-cycle watchdog error pulse |

## Verification
The bench goes after the wrap at zero. An off-by-one there would either skip the late error or fire it one tick early, and the reload value seen at address 3 would be wrong. It writes the key twice with no tick in between, catching a design that forgets the tick-since-service history and reloads twice. It writes the wrong key, writes zeros over set configuration bits, and writes under locks and in low-power mode. A broken gate there shows up as a changed reload value, a cleared bit, or a read that is not zero. A randomised stretch with both tick sources active makes the reference model catch any error pulse that comes a cycle early or late, or is stretched.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CFG_W = 6;

  // bit positions inside the configuration register
  localparam int B_LK_CFG  = 0;
  localparam int B_LK_PRE  = 1;
  localparam int B_LK_TMR  = 2;
  localparam int B_LK_RLD  = 3;
  localparam int B_TICKSEL = 4;
  localparam int B_KEYED   = 5;

  typedef enum logic [1:0] {
    A_CFG  = 2'd0,
    A_RLD  = 2'd1,
    A_SVC  = 2'd2,
    A_LIVE = 2'd3
  } reg_addr_e;

  // set-only merge of configuration bits
  function automatic logic [CFG_W-1:0] cfg_merge(input logic [CFG_W-1:0] old_v,
                                                 input logic [CFG_W-1:0] wr_v);
    return old_v | wr_v;
  endfunction

  // next counter value on a tick: wrap to reload at zero
  function automatic logic [7:0] tick_next(input logic [7:0] cur,
                                           input logic [7:0] rld);
    return (cur == '0) ? rld : cur - 8'd1;
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             low_power,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [W-1:0]     bus_wdata,
  output logic [CFG_W-1:0] cfg_q,
  output logic [W-1:0]     rld_q,
  output logic             rld_wr,
  output logic             svc_wr
);
  logic cfg_open;
  logic rld_open;
  logic cfg_wr;

  assign cfg_open = !low_power && !cfg_q[B_LK_CFG];
  assign rld_open = !low_power && !cfg_q[B_LK_RLD];
  assign cfg_wr   = bus_wr && (bus_addr == A_CFG) && cfg_open;
  assign rld_wr   = bus_wr && (bus_addr == A_RLD) && rld_open;
  assign svc_wr   = bus_wr && (bus_addr == A_SVC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      rld_q <= '0;
    end else begin
      if (cfg_wr) cfg_q <= cfg_merge(cfg_q, bus_wdata[CFG_W-1:0]);
      if (rld_wr) rld_q <= bus_wdata;
    end
  end
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int         W   = 8,
  parameter logic [W-1:0] KEY = 8'h5C
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_clk_in,
  input  logic         tick_tmr_out,
  input  logic         tick_sel,
  input  logic         keyed,
  input  logic         rld_wr,
  input  logic         svc_wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] rld_q,
  output logic [W-1:0] cnt_q,
  output logic         run_q,
  output logic         tick,
  output logic         svc_evt,
  output logic         err_evt,
  output logic         err_q
);
  logic since_svc_q;
  logic start, svc_req, svc_ok, bad_key, too_often, late;
  logic [W-1:0] load_val;

  assign tick      = tick_sel ? tick_tmr_out : tick_clk_in;
  assign start     = !run_q && (rld_wr || svc_wr);
  assign load_val  = rld_wr ? wdata : rld_q;
  assign svc_req   = run_q && (keyed ? (svc_wr && wdata == KEY) : rld_wr);
  assign bad_key   = run_q && keyed && svc_wr && (wdata != KEY);
  assign too_often = svc_req && since_svc_q;
  assign svc_ok    = svc_req && !since_svc_q;
  assign late      = run_q && tick && (cnt_q == '0) && !svc_ok;
  assign svc_evt   = start || svc_ok;
  assign err_evt   = bad_key || too_often || late;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      run_q       <= 1'b0;
      since_svc_q <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      err_q <= err_evt;
      if (start) run_q <= 1'b1;
      if (svc_evt)          cnt_q <= load_val;
      else if (run_q && tick) cnt_q <= tick_next(cnt_q, rld_q);
      if (svc_evt)   since_svc_q <= 1'b1;
      else if (tick) since_svc_q <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int           W   = 8,
  parameter logic [W-1:0] KEY = 8'h5C
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_clk_in,
  input  logic         tick_tmr_out,
  input  logic         low_power,
  input  logic         bus_wr,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  output logic         lock_prescaler,
  output logic         lock_timer,
  output logic         wd_err
);
  localparam int PAD = W - CFG_W;

  logic [CFG_W-1:0] cfg_q;
  logic [W-1:0]     rld_q;
  logic [W-1:0]     cnt_q;
  logic             rld_wr, svc_wr;
  logic             run_q, tick, svc_evt, err_evt;

  wdog_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .low_power(low_power),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .cfg_q(cfg_q), .rld_q(rld_q), .rld_wr(rld_wr), .svc_wr(svc_wr)
  );

  wdog_core #(.W(W), .KEY(KEY)) u_core (
    .clk(clk), .rst_n(rst_n),
    .tick_clk_in(tick_clk_in), .tick_tmr_out(tick_tmr_out),
    .tick_sel(cfg_q[B_TICKSEL]), .keyed(cfg_q[B_KEYED]),
    .rld_wr(rld_wr), .svc_wr(svc_wr), .wdata(bus_wdata), .rld_q(rld_q),
    .cnt_q(cnt_q), .run_q(run_q), .tick(tick),
    .svc_evt(svc_evt), .err_evt(err_evt), .err_q(wd_err)
  );

  always_comb begin
    bus_rdata = '0;
    if (!low_power) begin
      case (bus_addr)
        A_CFG:   if (!cfg_q[B_LK_CFG]) bus_rdata = {{PAD{1'b0}}, cfg_q};
        A_RLD:   if (!cfg_q[B_LK_RLD]) bus_rdata = rld_q;
        A_LIVE:  bus_rdata = cnt_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign lock_prescaler = cfg_q[B_LK_PRE];
  assign lock_timer     = cfg_q[B_LK_TMR];
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         low_power,
  input logic         bus_wr,
  input logic [1:0]   bus_addr,
  input logic [5:0]   cfg_q,
  input logic [W-1:0] rld_q,
  input logic [W-1:0] cnt_q,
  input logic         run_q,
  input logic         tick,
  input logic         svc_evt,
  input logic         err_evt,
  input logic         wd_err
);
  a_r1_idle_no_error: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !err_evt);

  a_r2_runs_until_reset: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> run_q);

  a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick && cnt_q != '0 && !svc_evt) |=> (cnt_q == $past(cnt_q) - 1'b1));

  a_r9_err_follows_event: assert property (@(posedge clk) disable iff (!rst_n)
    wd_err |-> $past(err_evt));

  a_r9_event_gives_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> wd_err);

  a_r10_cfg_set_only: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_q & $past(cfg_q)) == $past(cfg_q)));

  a_r11_reload_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1 && cfg_q[3]) |=> $stable(rld_q));

  a_r11_cfg_lock: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[0] |=> $stable(cfg_q));

  a_r12_low_power_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && low_power && bus_addr != 2'd2) |=> ($stable(cfg_q) && $stable(rld_q)));
endmodule

bind wdog_keyed wdog_keyed_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .low_power(low_power),
  .bus_wr(bus_wr), .bus_addr(bus_addr),
  .cfg_q(cfg_q), .rld_q(rld_q), .cnt_q(cnt_q), .run_q(run_q),
  .tick(tick), .svc_evt(svc_evt), .err_evt(err_evt), .wd_err(wd_err)
);

// File: tb/wdog_keyed_test.sv
`timescale 1ns/100ps
module wdog_keyed_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_clk_in = 1'b0, tick_tmr_out = 1'b0, low_power = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd3;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       lock_prescaler, lock_timer, wd_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdog_keyed uut (
    .clk(clk), .rst_n(rst_n), .tick_clk_in(tick_clk_in), .tick_tmr_out(tick_tmr_out),
    .low_power(low_power), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .lock_prescaler(lock_prescaler), .lock_timer(lock_timer),
    .wd_err(wd_err)
  );

  // ---------------- behavioural reference ----------------
  int  m_cfg, m_rld, m_cnt;
  bit  m_run, m_fresh, m_err;

  always @(posedge clk) begin
    int  cfg_n, rld_n, cnt_n;
    bit  run_n, fresh_n, err_n, t, rld_hit, svc_hit, serviced;
    if (!rst_n) begin
      m_cfg <= 0; m_rld <= 0; m_cnt <= 0; m_run <= 0; m_fresh <= 0; m_err <= 0;
    end else begin
      cfg_n = m_cfg; rld_n = m_rld; cnt_n = m_cnt; run_n = m_run;
      fresh_n = m_fresh; err_n = 0; serviced = 0;
      t = m_cfg[4] ? tick_tmr_out : tick_clk_in;
      rld_hit = bus_wr && bus_addr == 1 && !low_power && !m_cfg[3];
      svc_hit = bus_wr && bus_addr == 2;
      if (bus_wr && bus_addr == 0 && !low_power && !m_cfg[0])
        cfg_n = m_cfg | (bus_wdata & 8'h3F);
      if (rld_hit) rld_n = bus_wdata;
      if (!m_run) begin
        if (rld_hit) begin run_n = 1; cnt_n = bus_wdata; serviced = 1; end
        else if (svc_hit) begin run_n = 1; cnt_n = m_rld; serviced = 1; end
      end else begin
        bit want;
        want = m_cfg[5] ? (svc_hit && bus_wdata == 8'h5C) : rld_hit;
        if (m_cfg[5] && svc_hit && bus_wdata != 8'h5C) err_n = 1;
        if (want) begin
          if (m_fresh) err_n = 1;
          else begin cnt_n = rld_hit ? bus_wdata : m_rld; serviced = 1; end
        end
        if (!serviced && t) begin
          if (m_cnt == 0) begin err_n = 1; cnt_n = m_rld; end
          else cnt_n = m_cnt - 1;
        end
      end
      if (serviced) fresh_n = 1;
      else if (t) fresh_n = 0;
      m_cfg <= cfg_n; m_rld <= rld_n; m_cnt <= cnt_n; m_run <= run_n;
      m_fresh <= fresh_n; m_err <= err_n;
    end
  end

  function automatic int model_read(input int a);
    if (low_power) return 0;
    case (a)
      0: return m_cfg[0] ? 0 : m_cfg;
      1: return m_cfg[3] ? 0 : m_rld;
      3: return m_cnt;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R9 error pulse", wd_err, m_err);
      chk((bus_addr == 0) ? "R10 cfg read" : (bus_addr == 1) ? "R5 reload read" :
          (bus_addr == 2) ? "R12 service read" : "R4 live count", bus_rdata, model_read(bus_addr));
      chk("R11 lock outputs", {lock_prescaler, lock_timer}, {m_cfg[1], m_cfg[2]});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int a, input int d);
    @(negedge clk); #1;
    bus_wr = 1; bus_addr = a[1:0]; bus_wdata = d[7:0];
    @(negedge clk); #1;
    bus_wr = 0; bus_addr = 2'd3;
  endtask

  task automatic rd_check(input int a, input int exp, input string tag);
    @(negedge clk); #1;
    bus_addr = a[1:0];
    @(negedge clk);
    chk(tag, bus_rdata, exp);
    #1 bus_addr = 2'd3;
  endtask

  task automatic pulse(input bit which_out);
    @(negedge clk); #1;
    if (which_out) tick_tmr_out = 1; else tick_clk_in = 1;
    @(negedge clk); #1;
    tick_tmr_out = 0; tick_clk_in = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    rst_n = 0; bus_wr = 0; bus_addr = 2'd3; low_power = 0;
    tick_clk_in = 0; tick_tmr_out = 0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- directed and random sequences ----------------
  initial begin
    do_reset();
    // R1: reset state and idle counter
    rd_check(0, 0, "R1 cfg after reset");
    rd_check(3, 0, "R1 idle counter");
    for (int i = 0; i < 6; i++) begin pulse(0); pulse(1); end
    rd_check(3, 0, "R1 ticks ignored while idle");
    chk("R1 no error while idle", wd_err, 0);

    // R2/R5: plain mode, input-clock tick
    wr(1, 5);
    rd_check(3, 5, "R2 start loads written value");
    pulse(0);
    rd_check(3, 4, "R4 decrement on tick");
    pulse(1);
    rd_check(3, 4, "R3 unselected tick ignored");
    wr(1, 7);
    rd_check(3, 7, "R5 plain service reload");
    wr(1, 9);
    chk("R8 too-often error", wd_err, 1);
    @(negedge clk);
    chk("R9 pulse lasts one cycle", wd_err, 0);
    rd_check(3, 7, "R8 no reload on too-often");
    rd_check(1, 9, "R5 stored value");

    // R4: late service wraps from zero
    for (int i = 0; i < 7; i++) pulse(0);
    rd_check(3, 0, "R4 reached zero");
    pulse(0);
    chk("R4 late error", wd_err, 1);
    rd_check(3, 9, "R4 reload after expiry");

    // R3: select timer output pulse
    wr(0, 8'h10);
    pulse(0);
    rd_check(3, 9, "R3 input clock ignored when bit4=1");
    pulse(1);
    rd_check(3, 8, "R3 output pulse counts");

    // R6/R7/R8: keyed mode
    wr(0, 8'h20);
    rd_check(0, 8'h30, "R10 bits merge");
    pulse(1);
    wr(2, 8'h5C);
    rd_check(3, 9, "R6 key reload");
    pulse(1);
    wr(1, 3);
    rd_check(3, 8, "R6 reload write is not service");
    pulse(1);
    wr(2, 8'h5C);
    rd_check(3, 3, "R6 key uses new stored value");
    pulse(1);
    wr(2, 8'h5D);
    chk("R7 wrong key error", wd_err, 1);
    rd_check(3, 2, "R7 counter unchanged");
    wr(2, 8'h5C);
    wr(2, 8'h5C);
    chk("R8 keyed too-often error", wd_err, 1);
    rd_check(3, 3, "R8 keyed no second reload");

    // R10: set-only configuration
    wr(0, 8'h00);
    rd_check(0, 8'h30, "R10 zero write clears nothing");
    wr(0, 8'hC0);
    rd_check(0, 8'h30, "R10 reserved bits read zero");

    // R12: low-power gate
    @(negedge clk); #1 low_power = 1;
    rd_check(0, 0, "R12 cfg read blocked");
    wr(1, 8'h77);
    wr(0, 8'h08);
    pulse(1);
    wr(2, 8'h5C);
    rd_check(3, 0, "R12 live read blocked");
    @(negedge clk); #1 low_power = 0;
    rd_check(3, 3, "R12 service accepted in low power");
    rd_check(1, 3, "R12 reload write ignored");
    rd_check(0, 8'h30, "R12 cfg write ignored");

    // R11: locks
    wr(0, 8'h08);
    rd_check(1, 0, "R11 locked reload reads zero");
    wr(1, 8'h44);
    pulse(1);
    wr(2, 8'h5C);
    rd_check(3, 3, "R11 locked reload write ignored");
    wr(0, 8'h06);
    chk("R11 prescaler lock out", lock_prescaler, 1);
    chk("R11 timer lock out", lock_timer, 1);
    wr(0, 8'h01);
    rd_check(0, 0, "R11 locked cfg reads zero");
    wr(0, 8'h3F);
    rd_check(3, 3, "R11 cfg lock holds");

    // random stretch, reference compared every clock
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      int r;
      @(negedge clk); #1;
      tick_clk_in  = ($urandom % 3) == 0;
      tick_tmr_out = ($urandom % 7) == 0;
      if (($urandom % 64) == 0) low_power = ~low_power;
      r = $urandom % 10;
      bus_wr = (r < 3);
      bus_addr = 2'($urandom % 4);
      if (bus_addr == 2 && ($urandom % 2) == 0) bus_wdata = 8'h5C;
      else if (bus_addr == 0) bus_wdata = 8'($urandom) & 8'h3E;
      else bus_wdata = 8'($urandom % 24);
    end
    @(negedge clk); #1;
    bus_wr = 0; tick_clk_in = 0; tick_tmr_out = 0;
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule